// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects a set of level-held interrupt request lines and turns them into one request line for a CPU core. Each request first passes through a per-source enable bit. A fixed priority encoder then picks the surviving request with the lowest index. That source's 8-bit low vector is driven out, one register stage after the request is seen. Source vectors are even numbers spaced two apart, because each vector slot holds a two-byte handler address.

Software writes an 8-bit page register and the enable bytes through a small write-only register port. When the CPU acknowledges, the block captures the page in bits [15:8] and the current vector in bits [7:0]. That 16-bit handler-pointer address is held until the next acknowledge. Requests are not latched, so a source has to keep its line asserted until its handler starts.

Top module: `ivc_top`

## Requirements
- R1: Source i has the low vector VEC_BASE + VEC_STEP*i, with VEC_STEP = 2, and among enabled active sources the lowest index wins (for example, with VEC_BASE = 10h, source 0 gives 10h and source 11 gives 26h).
- R2: `cpu_irq_o` is high in the cycle after any enabled request is high at a rising clock edge, and low in the cycle after none is.
- R3: `vec_o` shows the winning vector in the same cycle as `cpu_irq_o`, and keeps its previous value while no enabled request is active.
- R4: Register address k (1 ≤ k ≤ number of mask bytes) writes enable bits 8(k-1) to 8(k-1)+7 from `reg_wdata_i`, where a 1 enables the source. A disabled source never raises `cpu_irq_o` or selects a vector. After reset every source is enabled.
- R5: Register address 0 writes the page register, which resets to 00h.
- R6: When `ack_i` is high at a rising edge, `vec_addr_o` takes {page, `vec_o`} as they were before that edge, and it stays unchanged until the next acknowledge, whatever the requests do.
- R7: Requests are not latched: a request that drops before acknowledge takes `cpu_irq_o` low one cycle later.
- R8: A write to a register address above the last mask byte changes neither the page nor the enables.
- R9: While in reset and right after it, `cpu_irq_o` is 0, `vec_o` is 00h and `vec_addr_o` is 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_i | input | NUM_SRC | Level-held interrupt requests, index 0 highest priority |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address: 0 = page, 1.. = enable bytes |
| reg_wdata_i | input | 8 | Register write data |
| ack_i | input | 1 | CPU acknowledge pulse |
| cpu_irq_o | output | 1 | Combined request to the CPU |
| vec_o | output | 8 | Low vector of the winning source |
| vec_addr_o | output | 16 | Captured {page, vector} handler-pointer address |

## Verification
The bench builds the block with NUM_SRC = 12, VEC_BASE = 10h and the default step of 2. With twelve sources the enable mask spans two bytes, and the upper byte is only partly used, so byte-lane decoding gets exercised. A 2-bit address then leaves address 3 unmapped, which lets the bench test writes to a hole in the map. The nonzero base shows that vectors are offset from the base and not from zero, and the top source's vector 26h shows that the step arithmetic holds at the far end.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0]   vec_t;
  typedef logic [2*BYTE_W-1:0] vaddr_t;
endpackage

// File: rtl/ivc_regs.sv
module ivc_regs
  import ivc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  vec_t               wdata_i,
  output vec_t               page_o,
  output logic [NUM_SRC-1:0] mask_o
);
  localparam int MASK_BYTES = (NUM_SRC + BYTE_W - 1) / BYTE_W;

  vec_t page_q, page_d;
  logic page_en;

  assign page_en = wr_i && (addr_i == ADDR_W'(0));

  always_comb begin
    page_d = page_q;
    if (page_en) page_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page_q <= '0;
    else        page_q <= page_d;
  end

  assign page_o = page_q;

  for (genvar b = 0; b < MASK_BYTES; b++) begin : g_mask_byte
    localparam int LO = b * BYTE_W;
    localparam int W  = ((NUM_SRC - LO) > BYTE_W) ? BYTE_W : (NUM_SRC - LO);
    logic [W-1:0] byte_q, byte_d;
    logic         byte_en;

    assign byte_en = wr_i && (addr_i == ADDR_W'(b + 1));

    always_comb begin
      byte_d = byte_q;
      if (byte_en) byte_d = wdata_i[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= '1;
      else        byte_q <= byte_d;
    end

    assign mask_o[LO +: W] = byte_q;
  end
endmodule

// File: rtl/ivc_prio_enc.sv
module ivc_prio_enc #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [NUM_SRC-1:0] gated;

  assign gated = req_i & mask_i;
  assign any_o = |gated;

  always_comb begin
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (gated[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/ivc_vec_out.sv
module ivc_vec_out
  import ivc_pkg::*;
#(
  parameter int   NUM_SRC  = 8,
  parameter int   IDX_W    = 3,
  parameter vec_t VEC_BASE = 8'h00,
  parameter int   VEC_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_i,
  input  logic [IDX_W-1:0] idx_i,
  input  vec_t             page_i,
  input  logic             ack_i,
  output logic             cpu_irq_o,
  output vec_t             vec_o,
  output vaddr_t           vec_addr_o
);
  logic   irq_q, irq_d;
  vec_t   vec_q, vec_d, vec_sel;
  vaddr_t addr_q, addr_d;

  assign vec_sel = vec_t'(int'(VEC_BASE) + VEC_STEP * int'(idx_i));

  always_comb begin
    irq_d  = any_i;
    vec_d  = vec_q;
    addr_d = addr_q;
    if (any_i) vec_d  = vec_sel;
    if (ack_i) addr_d = {page_i, vec_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      vec_q  <= '0;
      addr_q <= '0;
    end else begin
      irq_q  <= irq_d;
      vec_q  <= vec_d;
      addr_q <= addr_d;
    end
  end

  assign cpu_irq_o  = irq_q;
  assign vec_o      = vec_q;
  assign vec_addr_o = addr_q;
endmodule

// File: rtl/ivc_top.sv
module ivc_top
  import ivc_pkg::*;
#(
  parameter int   NUM_SRC  = 8,
  parameter vec_t VEC_BASE = 8'h00,
  parameter int   VEC_STEP = 2,
  parameter int   ADDR_W   = $clog2(((NUM_SRC + 7) / 8) + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [7:0]         reg_wdata_i,
  input  logic               ack_i,
  output logic               cpu_irq_o,
  output logic [7:0]         vec_o,
  output logic [15:0]        vec_addr_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  vec_t               page;
  logic [NUM_SRC-1:0] mask;
  logic               any;
  logic [IDX_W-1:0]   idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ivc_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .page_o  (page),
    .mask_o  (mask)
  );

  ivc_prio_enc #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_enc (
    .req_i  (irq_i),
    .mask_i (mask),
    .any_o  (any),
    .idx_o  (idx)
  );

  ivc_vec_out #(
    .NUM_SRC (NUM_SRC),
    .IDX_W   (IDX_W),
    .VEC_BASE(VEC_BASE),
    .VEC_STEP(VEC_STEP)
  ) u_out (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .any_i      (any),
    .idx_i      (idx),
    .page_i     (page),
    .ack_i      (ack_i),
    .cpu_irq_o  (cpu_irq_o),
    .vec_o      (vec_o),
    .vec_addr_o (vec_addr_o)
  );
endmodule

// File: rtl/ivc_chk.sv
module ivc_chk #(
  parameter int         NUM_SRC  = 8,
  parameter logic [7:0] VEC_BASE = 8'h00,
  parameter int         VEC_STEP = 2,
  parameter int         ADDR_W   = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] irq_i,
  input logic [NUM_SRC-1:0] mask,
  input logic               reg_wr_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [7:0]         reg_wdata_i,
  input logic [7:0]         page,
  input logic               ack_i,
  input logic               cpu_irq_o,
  input logic [7:0]         vec_o,
  input logic [15:0]        vec_addr_o
);
  // R2 / R7: no enabled request means the CPU request is low next cycle
  p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_i & mask) == '0) |=> !cpu_irq_o);

  // R2: any enabled request raises the CPU request next cycle
  p_req_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_i & mask) != '0) |=> cpu_irq_o);

  // R1: the top-priority source always wins when it is enabled
  p_top_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_i[0] && mask[0]) |=> (vec_o == VEC_BASE));

  // R3: vector holds while nothing enabled is active
  p_vec_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_i & mask) == '0) |=> $stable(vec_o));

  // R6: captured address holds without acknowledge
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> $stable(vec_addr_o));

  // R6: acknowledge captures page and the vector shown before the edge
  p_addr_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> (vec_addr_o == {$past(page), $past(vec_o)}));

  // R5: a write to address 0 loads the page
  p_page_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == '0) |=> (page == $past(reg_wdata_i)));

  // R1: a raised request always carries an on-grid vector
  p_vec_grid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq_o |-> (((int'(vec_o) - int'(VEC_BASE)) % VEC_STEP) == 0));
endmodule

bind ivc_top ivc_chk #(
  .NUM_SRC (NUM_SRC),
  .VEC_BASE(VEC_BASE),
  .VEC_STEP(VEC_STEP),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .irq_i      (irq_i),
  .mask       (mask),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .page       (page),
  .ack_i      (ack_i),
  .cpu_irq_o  (cpu_irq_o),
  .vec_o      (vec_o),
  .vec_addr_o (vec_addr_o)
);

// File: tb/ivc_top_tb.sv
module ivc_top_tb;
  localparam int N      = 12;
  localparam int AW     = 2;
  localparam int NVEC   = 8;
  localparam int VW     = N + 1 + 8;

  // {irq[11:0], expected cpu_irq, expected vector}
  localparam logic [VW-1:0] VECS [NVEC] = '{
    {12'b0000_0000_0001, 1'b1, 8'h10},
    {12'b1000_0000_0000, 1'b1, 8'h26},
    {12'b1000_0001_0000, 1'b1, 8'h18},
    {12'b0000_0110_0000, 1'b1, 8'h1A},
    {12'b1111_1111_1110, 1'b1, 8'h12},
    {12'b0000_0000_0000, 1'b0, 8'h12},
    {12'b0100_0000_0000, 1'b1, 8'h24},
    {12'b0000_0000_0000, 1'b0, 8'h24}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  irq;
  logic          wr;
  logic [AW-1:0] addr;
  logic [7:0]    wdata;
  logic          ack;
  logic          cpu_irq;
  logic [7:0]    vec;
  logic [15:0]   vaddr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ivc_top #(.NUM_SRC(N), .VEC_BASE(8'h10), .VEC_STEP(2), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .ack_i(ack), .cpu_irq_o(cpu_irq), .vec_o(vec),
    .vec_addr_o(vaddr)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    step();
    wr = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    step();
    ack = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq = '0; wr = 1'b0; addr = '0; wdata = '0; ack = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 irq", {15'd0, cpu_irq}, 16'd0);
    chk("R9 vec", {8'd0, vec}, 16'h0000);
    chk("R9 addr", vaddr, 16'h0000);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R9 irq after", {15'd0, cpu_irq}, 16'd0);
    // R5: page resets to 00h, seen through an acknowledge
    do_ack();
    chk("R5 page reset", vaddr, 16'h0000);

    // R1 R2 R3: table walk
    for (int i = 0; i < NVEC; i++) begin
      irq = VECS[i][VW-1 -: N];
      step();
      chk("R2 table irq", {15'd0, cpu_irq}, {15'd0, VECS[i][8]});
      chk("R1 table vec", {8'd0, vec}, {8'd0, VECS[i][7:0]});
    end

    // R5 R6: page write and acknowledge capture
    wr_reg(2'd0, 8'hA5);
    irq = 12'b0000_0000_1000;
    step();
    chk("R3 src3", {8'd0, vec}, 16'h0016);
    do_ack();
    chk("R6 capture", vaddr, 16'hA516);
    irq = 12'b0000_0000_0001;
    step(); step();
    chk("R6 hold", vaddr, 16'hA516);
    chk("R1 src0 live", {8'd0, vec}, 16'h0010);
    do_ack();
    chk("R6 recapture", vaddr, 16'hA510);

    // R4: mask source 0
    wr_reg(2'd1, 8'hFE);
    step();
    chk("R4 masked src0 irq", {15'd0, cpu_irq}, 16'd0);
    chk("R4 masked vec hold", {8'd0, vec}, 16'h0010);
    irq = 12'b0010_0000_0001;
    step();
    chk("R4 src9 wins", {8'd0, vec}, 16'h0022);
    wr_reg(2'd2, 8'h00);
    irq = 12'b0010_0000_0000;
    step();
    chk("R4 upper byte masked", {15'd0, cpu_irq}, 16'd0);

    // R8: unmapped write leaves page and enables alone
    wr_reg(2'd3, 8'hFF);
    irq = 12'b0000_0000_0010;
    step();
    chk("R8 enables kept", {8'd0, vec}, 16'h0012);
    do_ack();
    chk("R8 page kept", vaddr, 16'hA512);
    irq = 12'b0000_0000_0001;
    step();
    chk("R8 src0 still off", {15'd0, cpu_irq}, 16'd0);

    // R7: a request dropped before acknowledge is not latched
    wr_reg(2'd1, 8'hFF);
    irq = 12'b0000_0000_0100;
    step();
    chk("R7 raised", {15'd0, cpu_irq}, 16'd1);
    irq = '0;
    step();
    chk("R7 dropped", {15'd0, cpu_irq}, 16'd0);
    chk("R3 held vec", {8'd0, vec}, 16'h0014);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule